// File: doc/BRIEF.md
# Mode-banked general register file

This block holds the general registers of a processor that runs in one of four operating modes: user, fast interrupt, interrupt and supervisor. Software sees fifteen logical registers, numbered 0 to 14. Some of those numbers resolve to physical copies that belong to a single mode. The file has one write port and two combinational read ports. Each port is addressed by a 4-bit logical index. A 2-bit mode request is registered, and the registered mode decides which physical bank each access reaches. A mode change therefore moves no data: it only changes the mapping used by later accesses.

Alongside the storage sits a small codec for the combined program-counter and status word. It packs a byte address, six flag bits and the mode into one 32-bit word. It also splits such a word back into those fields.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, every stored register clears to zero and the current mode returns to user (code 00). After reset, every read port returns zero.
- R2: Mode codes are 00 user, 01 fast interrupt, 10 interrupt and 11 supervisor. In user mode, logical indices 0 to 14 reach the shared copies.
- R3: In fast-interrupt mode, indices 8 to 14 reach copies private to that mode. Indices 0 to 7 reach the shared copies.
- R4: Interrupt mode and supervisor mode each own private copies of indices 13 and 14 only. Indices 0 to 12 reach the shared copies.
- R5: Changing modes any number of times, in any order, leaves the contents of every bank unchanged.
- R6: `cur_mode` takes the value of `mode_i` at the next rising clock edge. A write in the same cycle as a mode change goes to the bank of the mode in effect before the change.
- R7: Reads are combinational. A read of the register being written in that cycle returns the old value, and the new value is visible from the next cycle on.
- R8: Index 15 is not a register. A read of index 15 returns zero, and a write to index 15 changes no stored register.
- R9: `pk_word` carries `pk_flags` in bits 31..26, the address bits of `pk_pc` under mask 0x03FFFFFC in bits 25..2, and `pk_mode` in bits 1..0.
- R10: `up_pc` is `up_word` masked with 0x03FFFFFC, `up_flags` is bits 31..26 and `up_mode` is bits 1..0. Unpacking a packed word returns the flags and mode that were packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Requested operating mode, takes effect next cycle |
| cur_mode | output | 2 | Mode currently selecting the banks |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical write index |
| wr_data | input | DW | Write data |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | DW | Read data, port B |
| pk_pc | input | 32 | Byte address to pack |
| pk_flags | input | 6 | Flags to pack |
| pk_mode | input | 2 | Mode to pack |
| pk_word | output | 32 | Packed PC/status word |
| up_word | input | 32 | Word to unpack |
| up_pc | output | 32 | Unpacked aligned address |
| up_flags | output | 6 | Unpacked flags |
| up_mode | output | 2 | Unpacked mode |

## Verification
The assertions assume that `mode_i`, the indices and the write controls are known and settle before each rising edge. They also assume that `wr_en` is low for the whole time `rst_n` is low. The stability property further assumes that a read port whose index is held still with no write is not disturbed by anything else. The bench drives every input at the falling edge and holds `wr_en` low during reset. Its random phase draws indices from the full 4-bit range, so index 15 is exercised, while every access stays a legal port access.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int NLOG      = 15;
  localparam int FIQ_BASE  = 15;
  localparam int IRQ_BASE  = 22;
  localparam int SVC_BASE  = 24;
  localparam int NPHYS     = 26;
  localparam int SLOTW     = $clog2(NPHYS);
  localparam int FLAGW     = 6;
  localparam logic [31:0] ADDR_MASK = 32'h03FF_FFFC;

  typedef enum logic [1:0] {
    MD_USR = 2'b00,
    MD_FIQ = 2'b01,
    MD_IRQ = 2'b10,
    MD_SVC = 2'b11
  } mode_e;

  // logical index -> physical slot for a given mode
  function automatic logic [SLOTW-1:0] phys_slot(mode_e m, logic [3:0] idx);
    logic [SLOTW-1:0] s;
    s = SLOTW'(idx);
    if (m == MD_FIQ && idx >= 4'd8 && idx <= 4'd14)
      s = SLOTW'(FIQ_BASE) + SLOTW'(idx - 4'd8);
    else if (m == MD_IRQ && (idx == 4'd13 || idx == 4'd14))
      s = SLOTW'(IRQ_BASE) + SLOTW'(idx - 4'd13);
    else if (m == MD_SVC && (idx == 4'd13 || idx == 4'd14))
      s = SLOTW'(SVC_BASE) + SLOTW'(idx - 4'd13);
    return s;
  endfunction

  function automatic logic [31:0] pack_word(logic [31:0] pc, logic [FLAGW-1:0] fl,
                                            logic [1:0] md);
    return (32'(fl) << 26) | (pc & ADDR_MASK) | 32'(md);
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  mode_e            mode,
  input  logic [3:0]       idx,
  output logic [SLOTW-1:0] slot,
  output logic             hit
);
  assign hit  = (idx != 4'd15);
  assign slot = phys_slot(mode, idx);
endmodule

// File: rtl/reg_store.sv
module reg_store
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SLOTW-1:0] wslot,
  input  logic [DW-1:0]    wd,
  input  logic [SLOTW-1:0] ra_slot,
  output logic [DW-1:0]    ra_q,
  input  logic [SLOTW-1:0] rb_slot,
  output logic [DW-1:0]    rb_q
);
  logic [DW-1:0] q [NPHYS];

  for (genvar s = 0; s < NPHYS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q[s] <= '0;
      else if (we && wslot == SLOTW'(s))      q[s] <= wd;
    end
  end

  always_comb begin
    ra_q = '0;
    rb_q = '0;
    if (int'(ra_slot) < NPHYS) ra_q = q[ra_slot];
    if (int'(rb_slot) < NPHYS) rb_q = q[rb_slot];
  end
endmodule

// File: rtl/psr_codec.sv
module psr_codec
  import bank_pkg::*;
(
  input  logic [31:0]      pk_pc,
  input  logic [FLAGW-1:0] pk_flags,
  input  logic [1:0]       pk_mode,
  output logic [31:0]      pk_word,
  input  logic [31:0]      up_word,
  output logic [31:0]      up_pc,
  output logic [FLAGW-1:0] up_flags,
  output logic [1:0]       up_mode
);
  assign pk_word  = pack_word(pk_pc, pk_flags, pk_mode);
  assign up_pc    = up_word & ADDR_MASK;
  assign up_flags = up_word[31:26];
  assign up_mode  = up_word[1:0];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  output logic [1:0]    cur_mode,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic [31:0]   pk_pc,
  input  logic [5:0]    pk_flags,
  input  logic [1:0]    pk_mode,
  output logic [31:0]   pk_word,
  input  logic [31:0]   up_word,
  output logic [31:0]   up_pc,
  output logic [5:0]    up_flags,
  output logic [1:0]    up_mode
);
  localparam int NPORT = 3;  // 0 write, 1 read A, 2 read B

  mode_e mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_USR;
    else        mode_q <= mode_e'(mode_i);
  end
  assign cur_mode = mode_q;

  logic [3:0]       port_idx  [NPORT];
  logic [SLOTW-1:0] port_slot [NPORT];
  logic             port_hit  [NPORT];
  assign port_idx[0] = wr_idx;
  assign port_idx[1] = rd_a_idx;
  assign port_idx[2] = rd_b_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bank_map u_map (
      .mode (mode_q),
      .idx  (port_idx[p]),
      .slot (port_slot[p]),
      .hit  (port_hit[p])
    );
  end

  // named internal events for the checker
  logic          wr_fire;
  logic [DW-1:0] ra_raw, rb_raw;
  assign wr_fire = wr_en && port_hit[0];

  reg_store #(.DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_fire),
    .wslot   (port_slot[0]),
    .wd      (wr_data),
    .ra_slot (port_slot[1]),
    .ra_q    (ra_raw),
    .rb_slot (port_slot[2]),
    .rb_q    (rb_raw)
  );

  assign rd_a_data = port_hit[1] ? ra_raw : '0;
  assign rd_b_data = port_hit[2] ? rb_raw : '0;

  psr_codec u_psr (
    .pk_pc    (pk_pc),
    .pk_flags (pk_flags),
    .pk_mode  (pk_mode),
    .pk_word  (pk_word),
    .up_word  (up_word),
    .up_pc    (up_pc),
    .up_flags (up_flags),
    .up_mode  (up_mode)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic [1:0]    cur_mode,
  input logic          wr_en,
  input logic          wr_fire,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic [31:0]   pk_word,
  input logic [5:0]    pk_flags,
  input logic [1:0]    pk_mode,
  input logic [31:0]   up_word,
  input logic [5:0]    up_flags,
  input logic [1:0]    up_mode
);
  // R6: registered mode follows the request one edge later
  a_r6_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cur_mode == $past(mode_i));

  // R7: a committed write is visible next cycle in the same mode
  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 4'd15 &&
     $past(mode_i) == $past(cur_mode) && rd_a_idx == $past(wr_idx) &&
     cur_mode == $past(cur_mode)) |-> rd_a_data == $past(wr_data));

  // R5: no write and no mode change -> held read stays put
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && rd_b_idx == $past(rd_b_idx) &&
     cur_mode == $past(cur_mode)) |-> $stable(rd_b_data));

  // R8: index 15 reads zero and never fires a write
  a_r8_idx15_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd15 |-> rd_a_data == '0);
  a_r8_idx15_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_idx != 4'd15 && wr_en));

  // R9/R10: codec fields
  always_comb begin
    a_r9_pack_fields: assert (pk_word[31:26] == pk_flags && pk_word[1:0] == pk_mode);
    a_r10_unpack_fields: assert (up_flags == up_word[31:26] && up_mode == up_word[1:0]);
  end
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cur_mode(cur_mode),
  .wr_en(wr_en), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
  .rd_b_data(rd_b_data), .pk_word(pk_word), .pk_flags(pk_flags),
  .pk_mode(pk_mode), .up_word(up_word), .up_flags(up_flags), .up_mode(up_mode)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0]  mode_i = 0;
  logic [1:0]  cur_mode;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0, rd_a_idx = 0, rd_b_idx = 0;
  logic [31:0] wr_data = 0, rd_a_data, rd_b_data;
  logic [31:0] pk_pc = 0, pk_word, up_word = 0, up_pc;
  logic [5:0]  pk_flags = 0, up_flags;
  logic [1:0]  pk_mode = 0, up_mode;

  always #5 clk = ~clk;

  banked_regfile u0 (.*);

  int checks = 0, fails = 0;

  // behavioural model: shared set plus per-mode private sets
  logic [31:0] usr [15];
  logic [31:0] fiq [7];
  logic [31:0] irq [2];
  logic [31:0] svc [2];
  int mm = 0;

  function automatic logic [31:0] mref(int m, int i);
    if (i == 15) return 0;
    if (m == 1 && i >= 8) return fiq[i-8];
    if (m == 2 && i >= 13) return irq[i-13];
    if (m == 3 && i >= 13) return svc[i-13];
    return usr[i];
  endfunction

  task automatic mwrite(int m, int i, logic [31:0] d);
    if (i == 15) return;
    if (m == 1 && i >= 8) fiq[i-8] = d;
    else if (m == 2 && i >= 13) irq[i-13] = d;
    else if (m == 3 && i >= 13) svc[i-13] = d;
    else usr[i] = d;
  endtask

  function automatic string tagof(int m, int i);
    if (i == 15) return "R8";
    if (m == 1 && i >= 8) return "R3";
    if (m >= 2 && i >= 13) return "R4";
    return "R2";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(int m, bit we, int wi, logic [31:0] wd, int ra, int rb, string tag);
    @(negedge clk);
    mode_i = 2'(m); wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
    #1;
    chk(tag == "" ? tagof(mm, ra) : tag, "rd_a", rd_a_data, mref(mm, ra));
    chk(tag == "" ? tagof(mm, rb) : tag, "rd_b", rd_b_data, mref(mm, rb));
    chk("R6", "cur_mode", 32'(cur_mode), 32'(mm));
    @(posedge clk);
    if (we) mwrite(mm, wi, wd);
    mm = m;
  endtask

  task automatic pchk(logic [31:0] pc, logic [5:0] fl, logic [1:0] md);
    logic [31:0] exp;
    @(negedge clk);
    pk_pc = pc; pk_flags = fl; pk_mode = md;
    exp = {fl, pc[25:2], md};
    up_word = exp;
    #1;
    chk("R9", "pk_word", pk_word, exp);
    chk("R10", "up_pc", up_pc, {6'b0, exp[25:2], 2'b0});
    chk("R10", "up_flags", 32'(up_flags), 32'(fl));
    chk("R10", "up_mode", 32'(up_mode), 32'(md));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    foreach (usr[i]) usr[i] = 0;
    foreach (fiq[i]) fiq[i] = 0;
    foreach (irq[i]) irq[i] = 0;
    foreach (svc[i]) svc[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: state during reset
    chk("R1", "cur_mode in reset", 32'(cur_mode), 0);
    chk("R1", "rd_a in reset", rd_a_data, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, i, 14 - i, "R1");

    // fill each bank through its own mode
    for (int i = 0; i < 15; i++) step(0, 1, i, 32'(i), i, 15, "");
    step(1, 0, 0, 0, 0, 0, "");
    for (int i = 8; i < 15; i++) step(1, 1, i, 32'(i) | 32'h100, i, 8, "");
    step(2, 0, 0, 0, 0, 0, "");
    for (int i = 13; i < 15; i++) step(2, 1, i, 32'(i) | 32'h200, i, 12, "");
    step(3, 0, 0, 0, 0, 0, "");
    for (int i = 13; i < 15; i++) step(3, 1, i, 32'(i) | 32'h300, i, 7, "");

    // R5: wander through modes without writes, reading everything
    for (int k = 0; k < 12; k++) begin
      int nm;
      nm = (k * 7 + 3) % 4;
      for (int i = 0; i < 16; i++) step(nm, 0, 0, 0, i, 15 - i, "R5");
    end

    // R6: write together with mode change lands in the old bank
    step(0, 0, 0, 0, 13, 14, "R6");
    step(3, 1, 13, 32'hA5A5_0013, 13, 0, "R6");
    step(3, 0, 0, 0, 13, 14, "R6");
    step(0, 0, 0, 0, 13, 14, "R6");
    step(0, 0, 0, 0, 13, 14, "R6");
    step(1, 1, 9, 32'hBEEF_0009, 9, 9, "R6");
    step(1, 0, 0, 0, 9, 9, "R6");
    step(0, 0, 0, 0, 9, 9, "R6");

    // R7: read of the written register shows old value, then new
    step(2, 1, 4, 32'h1111_2222, 4, 4, "R7");
    step(2, 1, 4, 32'h3333_4444, 4, 4, "R7");
    step(2, 0, 0, 0, 4, 4, "R7");
    step(2, 1, 14, 32'hCAFE_000E, 14, 14, "R7");
    step(2, 0, 0, 0, 14, 14, "R7");

    // R8: write to 15 changes nothing
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 15, 32'hFFFF_FFFF, 15, 0, "R8");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, i, 15, "R8");

    // random traffic over all modes and indices
    for (int k = 0; k < 3000; k++)
      step(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 15)), $urandom,
           int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), "");

    // R9/R10: status word packing
    pchk(32'h0000_0000, 6'h00, 2'b00);
    pchk(32'hFFFF_FFFF, 6'h3F, 2'b11);
    pchk(32'h0123_4567, 6'h2A, 2'b01);
    pchk(32'hFC00_0003, 6'h15, 2'b10);
    for (int c = 0; c < 256; c++)
      pchk($urandom, 6'((c & 8'hFC) >> 2), 2'(c & 3));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule